// File: doc/BRIEF.md
# Multichannel Serial Interrupt Aggregator

This block collects interrupt events from eight serial channels and presents them to a host in three forms: a six-flag identification byte per channel, a one-bit-per-channel pending vector, and a single latched host interrupt line. Each channel signals receive-FIFO trigger, transmit-FIFO empty and special receive condition as one-cycle pulses. It also supplies three raw modem inputs (carrier detect, clear-to-send, data-set-ready), whose changes are detected on either edge after synchronisation. The serial datapaths are outside the block.

A per-channel enable byte decides which flags count toward the pending vector. A control byte enables the host line, selects a periodic tick rate from a clock divider, and can restrict the host line to the tick alone. The host line latches high once a qualifying cause appears. It stays high until software writes the strobe bit. The host reaches all state through a byte-wide register port: combinational read data, and read-to-clear on the identification bytes.

Top module: `chan_irq_hub`

## Requirements
- R1: After reset, every identification byte, enable byte, the pending vector, the control byte and `host_irq` are all zero.
- R2: Identification byte of channel n (address n) holds flags that latch on their event: bit 5 receive trigger, bit 4 transmit empty, bit 3 special receive, bit 2 carrier-detect change, bit 1 clear-to-send change, bit 0 data-set-ready change; bits 7:6 read 0.
- R3: The receive-trigger flag sets even when the channel's receive enable is 0; the enable only decides whether it counts as pending.
- R4: Modem inputs pass through a synchroniser, and both a rising and a falling edge set the matching change flag.
- R5: A read of an identification byte returns its flags and clears them; an event arriving in the same cycle as the read stays set afterwards.
- R6: Enable byte of channel n is at address 8+n: bit 0 modem (gates ID bits 2:0), bit 1 receive trigger, bit 2 special receive, bit 3 transmit empty; bits 7:4 read 0.
- R7: The pending vector at address 16 has bit n set while channel n holds any flag whose enable is set.
- R8: The control byte at address 17 holds host enable (bit 3), rate code (bits 6:4) and periodic-only (bit 7); bits 2:0 read 0. With host enable set, `host_irq` rises one cycle after a cause appears and stays high after the cause goes away.
- R9: Writing control with bit 2 set clears `host_irq` at that edge. If a cause is still present, the line sets again on the next cycle.
- R10: Any control write restarts the tick divider. Rate code k in 1..6 gives a tick every BASE_DIV>>(k-1) cycles, so the line rises exactly that many cycles after the write. Codes 0 and 7 produce no tick.
- R11: In periodic-only mode, pending channels do not set `host_irq`; only the tick does.
- R12: With host enable at 0, nothing sets `host_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (triggers read-to-clear) |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| ev_rx_trig | input | 8 | Per-channel receive-trigger pulses |
| ev_tx_empty | input | 8 | Per-channel transmit-empty pulses |
| ev_rx_special | input | 8 | Per-channel special-receive pulses |
| cd_in | input | 8 | Raw carrier-detect inputs |
| cts_in | input | 8 | Raw clear-to-send inputs |
| dsr_in | input | 8 | Raw data-set-ready inputs |
| host_irq | output | 1 | Latched host interrupt line |

## Verification
The hardest case to reach is an event that lands in the same clock as the read that clears its identification byte. The stimulus raises the read strobe and a transmit pulse in one cycle and expects a zero readback followed by a second read showing the flag. The other delicate case is the exact tick timing for every rate code while a channel is pending in periodic-only mode. For this the bench keeps a channel pending and restarts the divider with a strobe-plus-rate write. It then checks that the line is still low one cycle before the computed period and high at the period.

// File: rtl/chan_irq_pkg.sv
package chan_irq_pkg;

  localparam int unsigned ID_W = 6;
  localparam int unsigned EN_W = 4;

  // identification flag positions
  localparam int unsigned ID_RX  = 5;
  localparam int unsigned ID_TX  = 4;
  localparam int unsigned ID_SRC = 3;
  localparam int unsigned ID_CD  = 2;
  localparam int unsigned ID_CTS = 1;
  localparam int unsigned ID_DSR = 0;

  // enable byte positions
  localparam int unsigned EN_MODEM = 0;
  localparam int unsigned EN_RX    = 1;
  localparam int unsigned EN_SRC   = 2;
  localparam int unsigned EN_TX    = 3;

  typedef struct packed {
    logic       per_only;
    logic [2:0] rate;
    logic       host_en;
  } hub_ctrl_t;

  // expand the 4-bit enable byte into a mask over the six id flags
  function automatic logic [ID_W-1:0] id_gate_mask(input logic [EN_W-1:0] en);
    logic [ID_W-1:0] m;
    m         = '0;
    m[ID_RX]  = en[EN_RX];
    m[ID_TX]  = en[EN_TX];
    m[ID_SRC] = en[EN_SRC];
    m[ID_CD]  = en[EN_MODEM];
    m[ID_CTS] = en[EN_MODEM];
    m[ID_DSR] = en[EN_MODEM];
    return m;
  endfunction

  // tick period in clocks for a rate code; 0 means no tick
  function automatic int unsigned pace_period(input int unsigned base, input logic [2:0] code);
    if (code == 3'd0 || code == 3'd7) return 0;
    return base >> (int'(code) - 1);
  endfunction

endpackage

// File: rtl/chan_irq_flags.sv
module chan_irq_flags
  import chan_irq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ev_rx,
  input  logic            ev_tx,
  input  logic            ev_src,
  input  logic            cd_raw,
  input  logic            cts_raw,
  input  logic            dsr_raw,
  input  logic            rd_clr,
  input  logic            en_wr,
  input  logic [EN_W-1:0] en_wdata,
  output logic [ID_W-1:0] id_flags,
  output logic [EN_W-1:0] en_q,
  output logic            pend
);

  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [2:0]      stg [SYNC_STAGES];
  logic [2:0]      stg_prev;
  logic [2:0]      modem_edge;
  logic [ID_W-1:0] set_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) stg[i] <= '0;
      stg_prev <= '0;
    end else begin
      stg[0] <= {cd_raw, cts_raw, dsr_raw};
      for (int i = 1; i < SYNC_STAGES; i++) stg[i] <= stg[i-1];
      stg_prev <= stg[LAST];
    end
  end

  assign modem_edge = stg[LAST] ^ stg_prev;

  always_comb begin
    set_vec         = '0;
    set_vec[ID_RX]  = ev_rx;
    set_vec[ID_TX]  = ev_tx;
    set_vec[ID_SRC] = ev_src;
    set_vec[ID_CD]  = modem_edge[2];
    set_vec[ID_CTS] = modem_edge[1];
    set_vec[ID_DSR] = modem_edge[0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      id_flags <= '0;
      en_q     <= '0;
    end else begin
      id_flags <= (rd_clr ? '0 : id_flags) | set_vec;
      if (en_wr) en_q <= en_wdata;
    end
  end

  assign pend = |(id_flags & id_gate_mask(en_q));

  assert_tx_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx |=> id_flags[ID_TX]);
  assert_rx_ungated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rx && !en_q[EN_RX]) |=> id_flags[ID_RX]);
  assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && set_vec == '0) |=> id_flags == '0);
  assert_pend_needs_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> id_flags != '0);

endmodule

// File: rtl/chan_irq_pacer.sv
module chan_irq_pacer
  import chan_irq_pkg::*;
#(
  parameter int unsigned BASE_DIV = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] rate_code,
  input  logic       restart,
  output logic       tick
);

  localparam int unsigned CNT_W = $clog2(BASE_DIV + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] period_w;
  logic             active;

  assign period_w = CNT_W'(pace_period(BASE_DIV, rate_code));
  assign active   = (period_w != '0);
  assign tick     = active && (cnt == period_w - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)                  cnt <= '0;
    else if (restart || !active) cnt <= '0;
    else if (tick)               cnt <= '0;
    else                         cnt <= cnt + CNT_W'(1);
  end

  assert_tick_needs_rate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (rate_code != 3'd0 && rate_code != 3'd7));
  assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> cnt < period_w);

endmodule

// File: rtl/chan_irq_hostline.sv
module chan_irq_hostline (
  input  logic clk,
  input  logic rst_n,
  input  logic host_en,
  input  logic per_only,
  input  logic pend_any,
  input  logic tick,
  input  logic strobe,
  output logic irq
);

  logic cause;

  assign cause = host_en && (tick || (!per_only && pend_any));

  always_ff @(posedge clk) begin
    if (!rst_n)      irq <= 1'b0;
    else if (strobe) irq <= 1'b0;
    else if (cause)  irq <= 1'b1;
  end

  assert_rise_has_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(host_en));
  assert_strobe_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !irq);
  assert_perionly_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && per_only && !tick) |=> !irq);
  assert_disabled_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !host_en) |=> !irq);

endmodule

// File: rtl/chan_irq_hub.sv
module chan_irq_hub
  import chan_irq_pkg::*;
#(
  parameter int unsigned NCH         = 8,
  parameter int unsigned BASE_DIV    = 256,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_W      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic [NCH-1:0]    ev_rx_trig,
  input  logic [NCH-1:0]    ev_tx_empty,
  input  logic [NCH-1:0]    ev_rx_special,
  input  logic [NCH-1:0]    cd_in,
  input  logic [NCH-1:0]    cts_in,
  input  logic [NCH-1:0]    dsr_in,
  output logic              host_irq
);

  localparam int unsigned EN_BASE = NCH;
  localparam int unsigned PEND_A  = 2 * NCH;
  localparam int unsigned CTRL_A  = 2 * NCH + 1;
  localparam int unsigned STROBE_BIT = 2;

  logic [ID_W-1:0] id_q [NCH];
  logic [EN_W-1:0] en_q [NCH];
  logic [NCH-1:0]  pend_vec;
  logic [7:0]      pend_byte;
  hub_ctrl_t       ctrl_q;
  logic            ctrl_wr;
  logic            strobe;
  logic            tick;

  assign ctrl_wr = reg_wr && (reg_addr == ADDR_W'(CTRL_A));
  assign strobe  = ctrl_wr && reg_wdata[STROBE_BIT];

  for (genvar n = 0; n < NCH; n++) begin : g_chan
    chan_irq_flags #(.SYNC_STAGES(SYNC_STAGES)) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev_rx    (ev_rx_trig[n]),
      .ev_tx    (ev_tx_empty[n]),
      .ev_src   (ev_rx_special[n]),
      .cd_raw   (cd_in[n]),
      .cts_raw  (cts_in[n]),
      .dsr_raw  (dsr_in[n]),
      .rd_clr   (reg_rd && (reg_addr == ADDR_W'(n))),
      .en_wr    (reg_wr && (reg_addr == ADDR_W'(EN_BASE + n))),
      .en_wdata (reg_wdata[EN_W-1:0]),
      .id_flags (id_q[n]),
      .en_q     (en_q[n]),
      .pend     (pend_vec[n])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= '{per_only: reg_wdata[7], rate: reg_wdata[6:4],
                                  host_en: reg_wdata[3]};
  end

  chan_irq_pacer #(.BASE_DIV(BASE_DIV)) u_pacer (
    .clk       (clk),
    .rst_n     (rst_n),
    .rate_code (ctrl_q.rate),
    .restart   (ctrl_wr),
    .tick      (tick)
  );

  chan_irq_hostline u_host (
    .clk      (clk),
    .rst_n    (rst_n),
    .host_en  (ctrl_q.host_en),
    .per_only (ctrl_q.per_only),
    .pend_any (|pend_vec),
    .tick     (tick),
    .strobe   (strobe),
    .irq      (host_irq)
  );

  always_comb begin
    pend_byte = '0;
    pend_byte[NCH-1:0] = pend_vec;
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NCH; i++) begin
      if (reg_addr == ADDR_W'(i))           reg_rdata = {{(8-ID_W){1'b0}}, id_q[i]};
      if (reg_addr == ADDR_W'(EN_BASE + i)) reg_rdata = {{(8-EN_W){1'b0}}, en_q[i]};
    end
    if (reg_addr == ADDR_W'(PEND_A)) reg_rdata = pend_byte;
    if (reg_addr == ADDR_W'(CTRL_A)) reg_rdata = {ctrl_q.per_only, ctrl_q.rate, ctrl_q.host_en, 3'b000};
  end

  assert_pend_zero_after_reset_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (pend_vec == '0 && !host_irq));
  assert_tick_only_with_rate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> ctrl_q.rate != 3'd0);

endmodule

// File: tb/chan_irq_hub_bench.sv
module chan_irq_hub_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BASE = 256;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [7:0] ev_rx = '0, ev_tx = '0, ev_src = '0, cd = '0, cts = '0, dsr = '0;
  logic       host_irq;
  int         n_checks = 0, n_fail = 0;
  logic       done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chan_irq_hub u_chan_irq_hub (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_rx_trig(ev_rx), .ev_tx_empty(ev_tx),
    .ev_rx_special(ev_src), .cd_in(cd), .cts_in(cts), .dsr_in(dsr), .host_irq(host_irq));

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic pulse(ref logic [7:0] v, input int ch);
    @(negedge clk); v[ch] = 1'b1;
    @(negedge clk); v[ch] = 1'b0;
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    for (int i = 0; i < 8; i++) begin rd(5'(i), d); check("R1 id", d, 8'h00); end
    for (int i = 8; i < 16; i++) begin rd(5'(i), d); check("R1 enable", d, 8'h00); end
    rd(5'd16, d); check("R1 pending", d, 8'h00);
    rd(5'd17, d); check("R1 control", d, 8'h00);
    check("R1 host_irq", {7'b0, host_irq}, 8'h00);
  endtask

  task automatic t_layout;
    logic [7:0] d;
    pulse(ev_tx, 3); pulse(ev_src, 3);
    rd(5'd3, d); check("R2 tx+special layout", d, 8'h18);
    rd(5'd3, d); check("R5 read clears", d, 8'h00);
    pulse(ev_rx, 0);
    rd(5'd16, d); check("R3 rx flag not pending with enable off", d, 8'h00);
    rd(5'd0, d); check("R3 rx flag set while disabled", d, 8'h20);
  endtask

  task automatic t_modem;
    logic [7:0] d;
    @(negedge clk); cd[5] = 1'b1; idle(5);
    rd(5'd5, d); check("R4 cd rise", d, 8'h04);
    @(negedge clk); cd[5] = 1'b0; idle(5);
    rd(5'd5, d); check("R4 cd fall", d, 8'h04);
    @(negedge clk); cts[5] = 1'b1; idle(5);
    rd(5'd5, d); check("R2 cts change bit", d, 8'h02);
    @(negedge clk); dsr[5] = 1'b1; idle(5);
    rd(5'd5, d); check("R2 dsr change bit", d, 8'h01);
  endtask

  task automatic t_read_race;
    logic [7:0] d;
    @(negedge clk); reg_rd = 1'b1; reg_addr = 5'd2; ev_tx[2] = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0; ev_tx[2] = 1'b0;
    check("R5 race read value", d, 8'h00);
    rd(5'd2, d); check("R5 event during read survives", d, 8'h10);
  endtask

  task automatic t_enables;
    logic [7:0] d;
    wr(5'd9, 8'hFF);
    rd(5'd9, d); check("R6 enable readback masked", d, 8'h0F);
    pulse(ev_src, 1);
    rd(5'd16, d); check("R7 special pending ch1", d, 8'h02);
    wr(5'd14, 8'h02);
    pulse(ev_tx, 6);
    rd(5'd16, d); check("R7 tx gated off ch6", d, 8'h02);
    pulse(ev_rx, 6);
    rd(5'd16, d); check("R7 rx pending ch6", d, 8'h42);
  endtask

  task automatic t_host;
    logic [7:0] d;
    idle(4); check("R12 host disabled stays low", {7'b0, host_irq}, 8'h00);
    wr(5'd17, 8'h08);
    idle(1); check("R8 host line sets", {7'b0, host_irq}, 8'h01);
    rd(5'd17, d); check("R8 control readback", d, 8'h08);
    wr(5'd17, 8'h0C);
    check("R9 strobe clears", {7'b0, host_irq}, 8'h00);
    idle(1); check("R9 re-set while cause persists", {7'b0, host_irq}, 8'h01);
    rd(5'd1, d); rd(5'd6, d);
    rd(5'd16, d); check("R7 pending cleared", d, 8'h00);
    check("R8 line latched after cause gone", {7'b0, host_irq}, 8'h01);
    wr(5'd17, 8'h0C); idle(3);
    check("R9 stays clear with no cause", {7'b0, host_irq}, 8'h00);
  endtask

  task automatic t_periodic;
    pulse(ev_src, 1);
    for (int code = 1; code <= 6; code++) begin
      int p;
      p = BASE >> (code - 1);
      wr(5'd17, 8'h8C | 8'(code << 4));
      idle(p - 1);
      check("R11 no channel irq before tick", {7'b0, host_irq}, 8'h00);
      idle(1);
      check("R10 tick at period", {7'b0, host_irq}, 8'h01);
    end
    wr(5'd17, 8'hFC); idle(2 * BASE);
    check("R10 code 7 no tick", {7'b0, host_irq}, 8'h00);
    wr(5'd17, 8'h8C); idle(2 * BASE);
    check("R11 periodic-only ignores pending", {7'b0, host_irq}, 8'h00);
    wr(5'd17, 8'h08); idle(1);
    check("R11 pending drives line outside periodic-only", {7'b0, host_irq}, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_layout();
    t_modem();
    t_read_race();
    t_enables();
    t_host();
    t_periodic();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired got %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule